// File: doc/BRIEF.md
# I2C Serial Memory Slave Front End

This block is the two-wire slave interface that sits in front of a 256-byte nonvolatile array and its write controller. SCL and SDA are brought into the system clock domain through flop synchronisers. START and STOP are found on the synchronised samples. The block shifts in a select byte and recognises two device types that share one three-bit chip-enable field. Type `1010` addresses the memory array and type `0110` addresses a protection register. Write data goes to the write controller one byte at a time, with an address and a target flag. A separate pulse marks the STOP that should start the nonvolatile program cycle. Read data is fetched from the array through a combinational read port.

SDA is modelled as an active-low open-drain enable: `sda_pull` high means the block pulls the line low. If the select byte does not match, or the write controller reports a cycle in progress, the block stays silent until the next START. A random read is an address write, then a repeated START, then a read select. The current-address pointer is kept between transactions.

The control state machine has these states:

- `ST_IDLE`: standby.
- `ST_DEVSEL`: receiving the select byte.
- `ST_DEV_ACK`: acknowledging the select byte.
- `ST_ADDR`: receiving the word address.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WDATA`: receiving a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: sending a read byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_HOLDOFF`: deselected and silent.

STOP leads from any state to `ST_IDLE`. START leads from any state to `ST_DEVSEL`, or to `ST_HOLDOFF` when the write controller is busy. The other transitions are:

- `ST_DEVSEL` goes to `ST_DEV_ACK` on a match and to `ST_HOLDOFF` otherwise.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`, and then on to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RD_ACK`. From there the block returns to `ST_RDATA` if the master acknowledged and goes to `ST_HOLDOFF` on a NoAck.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START, and it restarts select-byte reception from any state, including a repeated START inside a transaction. A rising SDA while SCL is high is a STOP, and it returns the block to standby with SDA released.
- R2: Bytes move most significant bit first. Incoming bits are taken on SCL rising edges. The block changes `sda_pull` only while SCL is low.
- R3: In the select byte, bits 7..4 are the type code (`1010` selects the array, `0110` selects the protection register), bits 3..1 must equal `chip_sel[2:0]`, and bit 0 is 1 for read and 0 for write. A matching select byte is acknowledged by pulling SDA low during the 9th clock.
- R4: A select byte with any other type code or a different chip-enable field gets no acknowledge, and the block ignores the bus until the next START.
- R5: While `wr_busy` is high at a START or at the end of the select byte, the block gives no acknowledge and ignores the transaction.
- R6: In a write, the address byte and every data byte are acknowledged. Each data byte produces a one-cycle `wr_req` carrying `wr_addr` and `wr_data`.
- R7: After each written byte, only address bits 3..0 of the pointer advance, wrapping inside the 16-byte row. Bits 7..4 keep their value.
- R8: A one-cycle `wr_commit` follows a STOP only when that STOP comes in the clock right after a data byte's acknowledge. A STOP in the middle of a byte, or in a write with no data byte, gives no commit.
- R9: A read select returns the byte at the current pointer. The pointer then advances by one over the full 8-bit range, so 0xFF wraps to 0x00.
- R10: Sequential read keeps sending bytes from the advancing pointer while the master acknowledges. A NoAck followed by STOP ends the read and returns the block to standby.
- R11: A random read (select for write, address byte, repeated START, select for read) returns data starting at the address that was sent.
- R12: When type `0110` is selected, `wr_reg` is high with `wr_req` and `rd_reg` is high during reads, so that the protection register is targeted.
- R13: After reset, `sda_pull`, `wr_req` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired bus level) |
| chip_sel | input | 3 | Chip-enable pattern compared with select bits 3..1 |
| wr_busy | input | 1 | Write controller is running a program cycle |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| wr_req | output | 1 | One-cycle strobe for a received data byte |
| wr_reg | output | 1 | Write targets the protection register |
| wr_addr | output | 8 | Byte address of the write |
| wr_data | output | 8 | Data byte of the write |
| wr_commit | output | 1 | One-cycle strobe starting the program cycle |
| rd_reg | output | 1 | Read targets the protection register |
| rd_addr | output | 8 | Current pointer, read address into the array |
| rd_data | input | 8 | Array or register byte at `rd_addr` |

## Verification
Every result trails the SCL edge that causes it by the two synchroniser flops plus one edge register. The acknowledge and each read bit appear on `sda_pull` about three system clocks after the SCL fall. The bench holds SCL low for eight clocks and samples SDA in the middle of the following high phase, so it never samples near a transition. `wr_req` and `wr_commit` arrive a few clocks after their SCL edge, and a bench model records them on every clock. Array contents, pointer wrap and commit counts are then compared after the STOP, once the bus is idle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_HOLDOFF
    } slv_state_e;

    localparam logic [3:0] TYPE_MEM = 4'b1010;
    localparam logic [3:0] TYPE_REG = 4'b0110;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '1;
        end else begin
            lvl_q <= lvl;
        end
    end

    assign scl_lvl  = lvl[0];
    assign sda_lvl  = lvl[1];
    assign scl_rise = lvl[0] & ~lvl_q[0];
    assign scl_fall = ~lvl[0] & lvl_q[0];
    assign start_ev = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
    assign stop_ev  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];

endmodule

// File: rtl/i2cs_addr.sv
module i2cs_addr #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_seq,
    input  logic          inc_page,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] page_next;

    if (PAGE_BITS >= AW) begin : g_flat
        assign page_next = ptr + 1'b1;
    end else begin : g_row
        logic [PAGE_BITS-1:0] low_next;
        assign low_next  = ptr[PAGE_BITS-1:0] + 1'b1;
        assign page_next = {ptr[AW-1:PAGE_BITS], low_next};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc_seq) begin
            ptr <= ptr + 1'b1;
        end else if (inc_page) begin
            ptr <= page_next;
        end
    end

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          sda_bit,
    input  logic [2:0]    chip_sel,
    input  logic          wr_busy,
    input  logic [AW-1:0] ptr,
    input  logic [7:0]    rd_data,
    output logic          sda_pull,
    output logic          wr_req,
    output logic          wr_reg,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_commit,
    output logic          rd_reg,
    output logic          ptr_load,
    output logic [AW-1:0] ptr_val,
    output logic          ptr_inc_seq,
    output logic          ptr_inc_page
);
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W);

    slv_state_e state, nxt;

    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              pull_q;
    logic              is_read_q;
    logic              is_reg_q;
    logic              has_data_q;
    logic              mst_nak_q;
    logic              wr_req_q;
    logic              commit_q;
    logic [AW-1:0]     wr_addr_q;
    logic [7:0]        wr_data_q;

    logic byte_done;
    logic type_mem;
    logic type_reg;
    logic dev_hit;
    logic rd_load;

    assign byte_done = scl_fall && (cnt_q == LAST_BIT);
    assign type_mem  = (sh_q[7:4] == TYPE_MEM);
    assign type_reg  = (sh_q[7:4] == TYPE_REG);
    assign dev_hit   = (type_mem || type_reg) && (sh_q[3:1] == chip_sel) && !wr_busy;

    assign rd_load = scl_fall &&
                     (((state == ST_DEV_ACK) && is_read_q) ||
                      ((state == ST_RD_ACK) && !mst_nak_q));

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = wr_busy ? ST_HOLDOFF : ST_DEVSEL;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_HOLDOFF:   nxt = ST_HOLDOFF;
                ST_DEVSEL:    if (byte_done) nxt = dev_hit ? ST_DEV_ACK : ST_HOLDOFF;
                ST_DEV_ACK:   if (scl_fall)  nxt = is_read_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)  nxt = mst_nak_q ? ST_HOLDOFF : ST_RDATA;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            pull_q     <= 1'b0;
            is_read_q  <= 1'b0;
            is_reg_q   <= 1'b0;
            has_data_q <= 1'b0;
            mst_nak_q  <= 1'b0;
            wr_req_q   <= 1'b0;
            commit_q   <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_req_q <= 1'b0;
            commit_q <= 1'b0;
            if (stop_ev) begin
                pull_q     <= 1'b0;
                commit_q   <= (state == ST_WDATA) && (cnt_q == CW'(1)) && has_data_q;
                has_data_q <= 1'b0;
            end else if (start_ev) begin
                pull_q     <= 1'b0;
                cnt_q      <= '0;
                has_data_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVSEL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise && cnt_q != LAST_BIT) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_bit};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (byte_done) begin
                            cnt_q <= '0;
                            if (state == ST_DEVSEL) begin
                                pull_q    <= dev_hit;
                                is_read_q <= sh_q[0];
                                is_reg_q  <= type_reg;
                            end else begin
                                pull_q <= 1'b1;
                            end
                            if (state == ST_WDATA) begin
                                wr_req_q   <= 1'b1;
                                wr_addr_q  <= ptr;
                                wr_data_q  <= sh_q;
                                has_data_q <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_nak_q <= sda_bit;
                        end
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                        end
                        if (rd_load) begin
                            sh_q   <= rd_data;
                            pull_q <= ~rd_data[7];
                            cnt_q  <= '0;
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && cnt_q != LAST_BIT) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (scl_fall) begin
                            if (cnt_q == LAST_BIT) begin
                                pull_q <= 1'b0;
                                cnt_q  <= '0;
                            end else begin
                                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                                pull_q <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_IDLE, ST_HOLDOFF: begin
                        pull_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ptr_load     = (state == ST_ADDR) && byte_done && !stop_ev && !start_ev;
    assign ptr_val      = sh_q[AW-1:0];
    assign ptr_inc_seq  = rd_load && !stop_ev && !start_ev;
    assign ptr_inc_page = (state == ST_WDATA) && byte_done && !stop_ev && !start_ev;

    assign sda_pull  = pull_q;
    assign wr_req    = wr_req_q;
    assign wr_reg    = is_reg_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign wr_commit = commit_q;
    assign rd_reg    = is_reg_q;

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
    parameter int AW          = 8,
    parameter int PAGE_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [2:0]    chip_sel,
    input  logic          wr_busy,
    output logic          sda_pull,
    output logic          wr_req,
    output logic          wr_reg,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_commit,
    output logic          rd_reg,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic          ptr_load, ptr_inc_seq, ptr_inc_page;
    logic [AW-1:0] ptr_val, ptr;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cs_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .sda_bit      (sda_lvl),
        .chip_sel     (chip_sel),
        .wr_busy      (wr_busy),
        .ptr          (ptr),
        .rd_data      (rd_data),
        .sda_pull     (sda_pull),
        .wr_req       (wr_req),
        .wr_reg       (wr_reg),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_commit    (wr_commit),
        .rd_reg       (rd_reg),
        .ptr_load     (ptr_load),
        .ptr_val      (ptr_val),
        .ptr_inc_seq  (ptr_inc_seq),
        .ptr_inc_page (ptr_inc_page)
    );

    i2cs_addr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_val),
        .inc_seq  (ptr_inc_seq),
        .inc_page (ptr_inc_page),
        .ptr      (ptr)
    );

    assign rd_addr = ptr;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          start_ev,
    input logic          stop_ev,
    input logic          sda_pull,
    input logic          wr_req,
    input logic          wr_commit,
    input logic          ptr_inc_page,
    input logic [AW-1:0] ptr
);
    p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_pull);

    p_drive_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_lvl));

    p_wrreq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    p_row_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_inc_page |=> (ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS])));

    p_commit_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_ev));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_lvl      (scl_lvl),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .sda_pull     (sda_pull),
    .wr_req       (wr_req),
    .wr_commit    (wr_commit),
    .ptr_inc_page (ptr_inc_page),
    .ptr          (ptr)
);

// File: tb/i2c_mem_slave_bench.sv
`timescale 1ns/1ps
module i2c_mem_slave_bench;
    localparam int QTR  = 4;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] chip_sel = 3'b101;
    logic       wr_busy = 1'b0;
    logic       sda_pull, wr_req, wr_reg, wr_commit, rd_reg;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    wire        sda_bus = m_sda & ~sda_pull;

    logic [7:0] mem [256];
    logic [7:0] prot = 8'h00;
    int         n_req = 0;
    int         n_commit = 0;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #4 clk = ~clk;

    i2c_mem_slave u_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .chip_sel(chip_sel), .wr_busy(wr_busy), .sda_pull(sda_pull),
        .wr_req(wr_req), .wr_reg(wr_reg), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .rd_reg(rd_reg), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign rd_data = rd_reg ? prot : mem[rd_addr];

    always @(posedge clk) begin
        if (wr_req) begin
            n_req <= n_req + 1;
            if (wr_reg) prot <= wr_data;
            else        mem[wr_addr] <= wr_data;
        end
        if (wr_commit) n_commit <= n_commit + 1;
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 3) & 8'hFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wclk(QTR);
        m_scl = 1'b1; wclk(HALF);
        m_sda = 1'b0; wclk(HALF);
        m_scl = 1'b0; wclk(1);
    endtask

    task automatic bus_stop;
        wclk(QTR);
        m_sda = 1'b0; wclk(QTR);
        m_scl = 1'b1; wclk(HALF);
        m_sda = 1'b1; wclk(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wclk(QTR); m_sda = b[i]; wclk(QTR);
            m_scl = 1'b1; wclk(HALF);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        wclk(QTR); m_sda = 1'b1; wclk(QTR);
        m_scl = 1'b1; wclk(HALF / 2);
        acked = ~sda_bus;
        wclk(HALF / 2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic nak, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wclk(HALF);
            m_scl = 1'b1; wclk(HALF / 2);
            b = {b[6:0], sda_bus};
            wclk(HALF / 2);
            m_scl = 1'b0;
        end
        wclk(QTR); m_sda = nak; wclk(QTR);
        m_scl = 1'b1; wclk(HALF);
        m_scl = 1'b0; wclk(1);
        m_sda = 1'b1;
    endtask

    localparam logic [7:0] SEL_WR  = 8'hAA;
    localparam logic [7:0] SEL_RD  = 8'hAB;
    localparam logic [7:0] REG_WR  = 8'h6A;
    localparam logic [7:0] REG_RD  = 8'h6B;

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         base_commit;
        int         base_req;
        for (int a = 0; a < 256; a++) mem[a] = init_val(a);
        wclk(5);
        // R13 reset state
        chk("R13 pull in reset", sda_pull, 0);
        chk("R13 wr_req in reset", wr_req, 0);
        chk("R13 commit in reset", wr_commit, 0);
        rst_n = 1'b1;
        wclk(5);
        chk("R13 pull after reset", sda_pull, 0);

        // R3/R4 sweep over every 7-bit select with the write bit
        for (int code = 0; code < 128; code++) begin
            logic exp_ack;
            exp_ack = ((code[6:3] == 4'b1010) || (code[6:3] == 4'b0110)) && (code[2:0] == 3'b101);
            bus_start();
            send_byte(8'(code << 1), ack);
            bus_stop();
            chk(exp_ack ? "R3 select ack" : "R4 select nak", ack, exp_ack);
        end
        chk("R8 no commit without data", n_commit, 0);
        chk("R4 no writes from selects", n_req, 0);

        // R3 chip-enable sweep
        for (int pins = 0; pins < 8; pins++) begin
            for (int f = 0; f < 8; f++) begin
                chip_sel = 3'(pins);
                bus_start();
                send_byte({4'b1010, 3'(f), 1'b0}, ack);
                bus_stop();
                chk(f == pins ? "R3 ce match" : "R4 ce mismatch", ack, f == pins);
            end
        end
        chip_sel = 3'b101;

        // R6/R8 page write inside one row
        bus_start();
        send_byte(SEL_WR, ack); chk("R6 sel ack", ack, 1);
        send_byte(8'h3C, ack);  chk("R6 addr ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'(8'h90 + i), ack); chk("R6 data ack", ack, 1);
        end
        bus_stop();
        wclk(4);
        for (int i = 0; i < 4; i++) chk("R6 array byte", mem[8'h3C + i], 8'h90 + i);
        chk("R8 commit after write", n_commit, 1);
        chk("R6 request count", n_req, 4);

        // R7 roll-over within row 5
        bus_start();
        send_byte(SEL_WR, ack);
        send_byte(8'h5E, ack);
        for (int i = 0; i < 4; i++) send_byte(8'(8'h40 + i), ack);
        bus_stop();
        wclk(4);
        for (int i = 0; i < 4; i++) chk("R7 rolled byte", mem[{4'h5, 4'(4'hE + i)}], 8'h40 + i);
        chk("R7 next row untouched", mem[8'h60], init_val(8'h60));
        chk("R8 second commit", n_commit, 2);

        // R9 current address read after roll-over: pointer 0x52
        bus_start();
        send_byte(SEL_RD, ack); chk("R9 read sel ack", ack, 1);
        recv_byte(1'b1, rb);
        bus_stop();
        chk("R9 R2 current read", rb, init_val(8'h52));

        // R11/R10/R9 random read with wrap, R1 repeated start
        bus_start();
        send_byte(SEL_WR, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte(SEL_RD, ack); chk("R1 ack after repeated start", ack, 1);
        recv_byte(1'b0, rb); chk("R11 first random byte", rb, init_val(8'hFE));
        recv_byte(1'b0, rb); chk("R10 sequential byte", rb, init_val(8'hFF));
        recv_byte(1'b1, rb); chk("R9 wrap to zero", rb, init_val(8'h00));
        bus_stop();
        chk("R8 no commit on read", n_commit, 2);
        bus_start();
        send_byte(SEL_RD, ack); chk("R10 standby then new read", ack, 1);
        recv_byte(1'b1, rb);
        bus_stop();
        chk("R10 pointer kept", rb, init_val(8'h01));

        // R8 STOP in the middle of a data byte
        base_req = n_req;
        bus_start();
        send_byte(SEL_WR, ack);
        send_byte(8'h10, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        wclk(4);
        chk("R8 no commit mid byte", n_commit, 2);
        chk("R8 no request mid byte", n_req, base_req);
        chk("R8 array untouched", mem[8'h10], init_val(8'h10));

        // R12 protection register write and read
        bus_start();
        send_byte(REG_WR, ack); chk("R12 reg sel ack", ack, 1);
        send_byte(8'h00, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        wclk(4);
        chk("R12 reg written", prot, 8'h5A);
        chk("R12 array untouched", mem[8'h00], init_val(0));
        chk("R8 reg commit", n_commit, 3);
        bus_start();
        send_byte(REG_RD, ack);
        recv_byte(1'b1, rb);
        bus_stop();
        chk("R12 reg read", rb, 8'h5A);

        // R5 busy write controller
        base_req = n_req;
        base_commit = n_commit;
        wr_busy = 1'b1;
        bus_start();
        send_byte(SEL_WR, ack); chk("R5 no ack when busy", ack, 0);
        send_byte(8'h20, ack);  chk("R5 address ignored", ack, 0);
        send_byte(8'h77, ack);  chk("R5 data ignored", ack, 0);
        bus_stop();
        wr_busy = 1'b0;
        wclk(4);
        chk("R5 no request", n_req, base_req);
        chk("R5 no commit", n_commit, base_commit);
        bus_start();
        send_byte(SEL_WR, ack); chk("R5 ack once idle", ack, 1);
        bus_stop();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule